// File: doc/BRIEF.md
# Bi-Quinary Decade Counter

This block is one decimal digit of an event counter. Each clock cycle in which the count enable is high counts one event. The count is held in two parts. A divide-by-two flip-flop toggles on every counted event. A five-stage odd-length twisted ring changes exactly one of its stages on each counted event. Together they pass through ten states per decade.

The decimal digit is not kept in a binary register. It is recovered from the ring. Each stage is compared with its neighbours to find the one place where two adjacent stages agree. The position and the value of that agreeing pair give the digit, and the flip-flop supplies the least significant bit. A one-cycle carry marks each wrap from 9 to 0 so that a following digit can count it.

Two reset paths are provided. A synchronous reset input clears the whole block. A separate active-low clear request, which normally sits high, is acted on only at its falling edge. That edge starts a short internal clear pulse that returns both sections to the zero-count state.

Top module: `biquinary_decade`

## Requirements
- R1: The binary stage toggles on every accepted count. It is driven out as bit 0 of `bcd_o`, so that bit alternates on each accepted count.
- R2: The ring has stages A..E, held in bits 0..4 of the ring register, and its order is A→B→C→D→E→A. On each accepted count, the single stage whose value equals that of its preceding stage is inverted, so exactly one ring stage changes.
- R3: From the zero pattern (A and C set; B, D and E clear), the ring passes through ten distinct patterns and then returns to zero. A pattern that does not have exactly one pair of equal adjacent stages is replaced by the zero pattern on the next clock.
- R4: `bcd_o` is registered and is never above 9. It gives the number of accepted counts modulo 10 as an unsigned binary value. It changes on the same clock edge that accepts the count.
- R5: `carry_o` is high for exactly the one cycle that follows the count that moves the digit from 9 to 0, and it is low at all other times.
- R6: While `rst` is high at a clock edge, the block goes to digit 0 with `carry_o` low.
- R7: A high-to-low transition of `clr_req_n` clears the block to digit 0 at that edge. The clear then holds for the next `CLR_CYCLES` edges, and counts during that time are ignored without a carry. Holding `clr_req_n` low does not start another clear.
- R8: A clock edge with `cnt_en` low leaves `bcd_o` unchanged and `carry_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_req_n | input | 1 | Clear request, normally high, acted on at its falling edge |
| cnt_en | input | 1 | Count one event in this cycle |
| bcd_o | output | 4 | Decimal digit 0..9, registered |
| carry_o | output | 1 | One-cycle pulse on the wrap from 9 to 0 |

## Verification
The properties assume that `rst` is held high for the first clock edge, so that the ring starts from a legal pattern. Apart from that, `cnt_en` and `clr_req_n` may take any value in any cycle. The stimulus starts with reset and then changes only these two inputs, always at the falling clock edge. It includes falling edges of the clear request that occur while counting is enabled, partway through a decade, and during a clear that is already active. It also includes a long low hold on the clear request and a synchronous reset partway through a count.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int unsigned RING_W = 5;
  localparam int unsigned DIG_W  = 4;
  // zero-count pattern, bit0 = stage A: A and C set
  localparam logic [RING_W-1:0] RING_ZERO = 5'b00101;
  typedef logic [RING_W-1:0] ring_t;
  typedef logic [DIG_W-1:0]  digit_t;
endpackage

// File: rtl/bq_clear_shaper.sv
module bq_clear_shaper #(
  parameter int unsigned CLR_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic clear_o
);
  localparam int unsigned CW = $clog2(CLR_CYCLES + 1);

  logic          prev_q;
  logic [CW-1:0] left_q;
  logic          fall;

  assign fall    = prev_q & ~req_n;
  assign clear_o = fall | (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      left_q <= '0;
    end else begin
      prev_q <= req_n;
      if (fall)
        left_q <= CW'(CLR_CYCLES);
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end

  // R7: a level held low after the pulse has expired does not clear again
  p_no_retrigger_r7: assert property (@(posedge clk) disable iff (rst)
    (!req_n && !prev_q && left_q == '0) |-> !clear_o);
endmodule

// File: rtl/bq_ring.sv
module bq_ring
  import bq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  adv,
  output ring_t ring_nxt_o,
  output logic  legal_o,
  output logic  wrap_o
);
  ring_t ring_q;
  ring_t eq;
  ring_t stepped;

  genvar k;
  generate
    for (k = 0; k < RING_W; k++) begin : g_cmp
      assign eq[k] = (ring_q[k] == ring_q[(k + RING_W - 1) % RING_W]);
    end
  endgenerate

  assign legal_o = ($countones(eq) == 1);
  assign stepped = ring_q ^ eq;

  always_comb begin
    if (clear || !legal_o)
      ring_nxt_o = RING_ZERO;
    else if (adv)
      ring_nxt_o = stepped;
    else
      ring_nxt_o = ring_q;
  end

  assign wrap_o = adv && !clear && legal_o && (stepped == RING_ZERO);

  always_ff @(posedge clk) begin
    if (rst) ring_q <= RING_ZERO;
    else     ring_q <= ring_nxt_o;
  end

  // R2: one stage changes per accepted count
  p_single_flip_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && legal_o) |=> $countones(ring_q ^ $past(ring_q)) == 1);
  // R3: illegal patterns recover to zero
  p_recover_r3: assert property (@(posedge clk) disable iff (rst)
    !legal_o |=> ring_q == RING_ZERO);
  // R7: clear forces the zero pattern
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> ring_q == RING_ZERO);
endmodule

// File: rtl/bq_decoder.sv
module bq_decoder
  import bq_pkg::*;
(
  input  ring_t  ring_i,
  output digit_t digit_o
);
  ring_t eq;

  genvar k;
  generate
    for (k = 0; k < RING_W; k++) begin : g_cmp
      assign eq[k] = (ring_i[k] == ring_i[(k + RING_W - 1) % RING_W]);
    end
  endgenerate

  logic [2:0] q;
  logic       v;

  always_comb begin
    q = '0;
    v = 1'b0;
    for (int i = 0; i < RING_W; i++) begin
      if (eq[i]) begin
        q = 3'((i + 1) % RING_W);
        v = ring_i[i];
      end
    end
    digit_o = {1'b0, q} + ((v != q[0]) ? 4'd5 : 4'd0);
  end
endmodule

// File: rtl/biquinary_decade.sv
module biquinary_decade #(
  parameter int unsigned CLR_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_req_n,
  input  logic       cnt_en,
  output logic [3:0] bcd_o,
  output logic       carry_o
);
  import bq_pkg::*;

  logic   clear;
  logic   legal;
  logic   wrap;
  ring_t  ring_nxt;
  digit_t dig_nxt;
  logic   bin_q;
  logic   bin_nxt;
  logic   counting;

  bq_clear_shaper #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
    .clk(clk), .rst(rst), .req_n(clr_req_n), .clear_o(clear)
  );

  bq_ring u_ring (
    .clk(clk), .rst(rst), .clear(clear), .adv(cnt_en),
    .ring_nxt_o(ring_nxt), .legal_o(legal), .wrap_o(wrap)
  );

  bq_decoder u_dec (
    .ring_i(ring_nxt), .digit_o(dig_nxt)
  );

  assign counting = cnt_en && !clear && legal;
  assign bin_nxt  = (clear || !legal) ? 1'b0 : (bin_q ^ cnt_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q   <= 1'b0;
      bcd_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      bin_q   <= bin_nxt;
      bcd_o   <= {dig_nxt[3:1], bin_nxt};
      carry_o <= wrap;
    end
  end

  // R1: least significant bit follows the binary stage toggle
  p_lsb_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    counting |=> bcd_o[0] != $past(bcd_o[0]));
  // R4: digit stays decimal
  p_bcd_range_r4: assert property (@(posedge clk) disable iff (rst)
    bcd_o <= 4'd9);
  // R5: carry only alongside digit zero
  p_carry_zero_r5: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> bcd_o == 4'd0);
  // R7: clear gives zero and no carry
  p_clear_out_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (bcd_o == 4'd0 && !carry_o));
  // R8: no count, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !clear && legal) |=> ($stable(bcd_o) && !carry_o));
endmodule

// File: tb/sim_biquinary_decade.sv
module sim_biquinary_decade;
  localparam int CLR = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_req_n = 1'b1;
  logic       cnt_en = 1'b0;
  logic [3:0] bcd_o;
  logic       carry_o;

  int checks = 0;
  int errors = 0;

  // behavioural model
  int m_cnt = 0;
  int m_left = 0;
  bit m_prev = 1'b1;
  bit m_carry = 1'b0;

  always #2 clk = ~clk;

  biquinary_decade #(.CLR_CYCLES(CLR)) u0 (
    .clk(clk), .rst(rst), .clr_req_n(clr_req_n), .cnt_en(cnt_en),
    .bcd_o(bcd_o), .carry_o(carry_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit clrn, input bit r);
    bit fall;
    @(negedge clk);
    cnt_en = en; clr_req_n = clrn; rst = r;
    @(posedge clk);
    if (r) begin
      m_cnt = 0; m_left = 0; m_prev = 1'b1; m_carry = 1'b0;
    end else begin
      fall = m_prev && !clrn;
      if (fall || m_left > 0) begin
        m_cnt = 0; m_carry = 1'b0;
        m_left = fall ? CLR : m_left - 1;
      end else if (en) begin
        m_carry = (m_cnt == 9);
        m_cnt = (m_cnt + 1) % 10;
      end else begin
        m_carry = 1'b0;
      end
      m_prev = clrn;
    end
    #1;
    check("R2 R3 R4 digit", int'(bcd_o), m_cnt);
    check("R5 carry", int'(carry_o), int'(m_carry));
    check("R1 lsb", int'(bcd_o[0]), m_cnt % 2);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R6 reset state
    step(1, 1, 1);
    step(1, 1, 1);
    check("R6 reset digit", int'(bcd_o), 0);
    check("R6 reset carry", int'(carry_o), 0);
    // R1 R2 R3 R4 R5: count 0..25
    for (int i = 0; i < 26; i++) step(1, 1, 0);
    // R8: hold with enable low, interleaved
    for (int i = 0; i < 12; i++) step(i % 3 != 0, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0);
    // R7: clear mid count with enable low
    step(0, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 0);
    // R7: clear while counting enabled, request pulsed again during clear
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    // R7: long low hold does not retrigger
    step(1, 0, 0);
    for (int i = 0; i < 14; i++) step(1, 0, 0);
    check("R7 no retrigger", int'(bcd_o), 12 % 10);
    step(1, 1, 0);
    // R5 wrap near clear and R6 reset mid count
    for (int i = 0; i < 9; i++) step(1, 1, 0);
    step(1, 1, 1);
    check("R6 mid reset", int'(bcd_o), 0);
    for (int i = 0; i < 23; i++) step(1, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule